// File: doc/BRIEF.md
# Bidirectional Pad Boundary-Scan Chain

This block is the boundary register that sits between a chip's core and a row of bidirectional I/O pads. Each pad owns a pair of scan cells. One cell holds the output-enable (3-state) value and the other holds the data value. A capture strobe loads the cells of every pad in the same cycle. A shift strobe moves the chain one place from `tdi_i` toward `tdo_o`. An update strobe copies the whole chain into a bank of update registers at once.

The test access controller and instruction decoder sit outside this block. They supply the strobes and a single external-test select. While the select is low, the pads carry the core's data and enable untouched, and the chain only observes them (sample/preload). While it is high, the update registers own the pads. A pad whose latched enable is set drives the latched data bit. A pad whose latched enable is clear is released, and its cell captures the level seen at the pad.

Top module: `bsr_chain`

## Requirements
- R1: While `rst_ni` is low, every scan cell and every update register is cleared. After reset, with the external-test select high, all pads are undriven (`pad_oe_o` = 0, `pad_do_o` = 0) and `tdo_o` = 0.
- R2: On a clock with `capture_i` high, all pads load into the chain in the same cycle. The enable cell of pad p (chain bit 2p) takes `pad_oe_o[p]`. The data cell (chain bit 2p+1) takes `pad_do_o[p]` when `pad_oe_o[p]` is 1, and `pad_di_i[p]` otherwise.
- R3: `tdo_o` shows chain bit 0, which is the enable cell of pad 0. On a clock with `shift_i` high and `capture_i` low, bit k takes bit k+1 and the top bit (2N-1, the data cell of pad N-1) takes `tdi_i`. The bits therefore leave as pad 0 enable, pad 0 data, pad 1 enable, and so on. The first bit shifted in reaches `tdo_o` after 2N shifts.
- R4: On a clock with `update_i` high, every update register loads the chain bit of the same index in the same cycle.
- R5: The update registers change only on an update clock. During shifting and capture, `pad_oe_o` and `pad_do_o` stay constant in external-test mode.
- R6: With `extest_i` = 1, `pad_oe_o[p]` equals the latched enable bit of pad p and `pad_do_o[p]` equals its latched data bit.
- R7: With `extest_i` = 0, `pad_oe_o` and `pad_do_o` equal `core_oe_i` and `core_do_i`. Shifting and updating do not change them.
- R8: In external-test mode, a pad whose latched enable is 0 captures `pad_di_i` into its data cell. A pad whose latched enable is 1 captures its own latched data value instead.
- R9: With `capture_i` and `shift_i` both low, the chain holds its value. When both are high, capture wins and no shift takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| capture_i | input | 1 | Parallel load of all cells |
| shift_i | input | 1 | Serial shift toward tdo_o |
| update_i | input | 1 | Transfer chain into update registers |
| extest_i | input | 1 | 1: update registers drive pads; 0: core drives pads |
| tdi_i | input | 1 | Serial data in |
| core_do_i | input | N_PADS | Core data toward pads |
| core_oe_i | input | N_PADS | Core output enables |
| pad_di_i | input | N_PADS | Level observed at each pad |
| pad_do_o | output | N_PADS | Data driven to pads |
| pad_oe_o | output | N_PADS | Pad output enables |
| tdo_o | output | 1 | Serial data out |

## Verification
The hardest case to reach is an external-test capture in which the pads differ in latched enable. In that case some pads must return their own driven bit and others the level on `pad_di_i`. The 3-state decision then shows up inside one captured word. To reach it, the bench shifts in and updates a pattern with mixed enables. It then applies a `pad_di_i` value that differs from the latched data on every pad, captures, and shifts the result out. Only the correct per-pad selection produces the expected word. A second pass shifts a new pattern through while sampling the pads on every cycle. This shows that shifting cannot ripple into the outputs before the update.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int CELLS_PER_PAD = 2;
  localparam int EN_OFS = 0;  // enable cell sits nearer tdo
  localparam int DO_OFS = 1;

  function automatic int en_idx(input int pad);
    return CELLS_PER_PAD * pad + EN_OFS;
  endfunction

  function automatic int do_idx(input int pad);
    return CELLS_PER_PAD * pad + DO_OFS;
  endfunction
endpackage

// File: rtl/bsr_scan_cell.sv
module bsr_scan_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic cap_d_i,
  input  logic ser_d_i,
  output logic scan_q_o,
  output logic upd_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        scan_q_o <= 1'b0;
    else if (capture_i) scan_q_o <= cap_d_i;
    else if (shift_i)   scan_q_o <= ser_d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       upd_q_o <= 1'b0;
    else if (update_i) upd_q_o <= scan_q_o;
  end
endmodule

// File: rtl/bsr_pad_mux.sv
module bsr_pad_mux (
  input  logic extest_i,
  input  logic core_do_i,
  input  logic core_oe_i,
  input  logic upd_do_i,
  input  logic upd_oe_i,
  input  logic pad_di_i,
  output logic pad_do_o,
  output logic pad_oe_o,
  output logic cap_en_o,
  output logic cap_do_o
);
  always_comb begin
    pad_do_o = extest_i ? upd_do_i : core_do_i;
    pad_oe_o = extest_i ? upd_oe_i : core_oe_i;
  end

  // released pad: observe the pin; driven pad: observe own drive
  assign cap_en_o = pad_oe_o;
  assign cap_do_o = pad_oe_o ? pad_do_o : pad_di_i;
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain #(
  parameter int N_PADS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              extest_i,
  input  logic              tdi_i,
  input  logic [N_PADS-1:0] core_do_i,
  input  logic [N_PADS-1:0] core_oe_i,
  input  logic [N_PADS-1:0] pad_di_i,
  output logic [N_PADS-1:0] pad_do_o,
  output logic [N_PADS-1:0] pad_oe_o,
  output logic              tdo_o
);
  import bsr_pkg::*;

  localparam int CHAIN_LEN = CELLS_PER_PAD * N_PADS;

  logic [CHAIN_LEN-1:0] scan_q;
  logic [CHAIN_LEN-1:0] upd_q;
  logic [CHAIN_LEN-1:0] cap_d;
  logic [CHAIN_LEN:0]   ser_in;

  assign ser_in = {tdi_i, scan_q};
  assign tdo_o  = scan_q[0];

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    bsr_scan_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .capture_i (capture_i),
      .shift_i   (shift_i),
      .update_i  (update_i),
      .cap_d_i   (cap_d[i]),
      .ser_d_i   (ser_in[i+1]),
      .scan_q_o  (scan_q[i]),
      .upd_q_o   (upd_q[i])
    );
  end

  for (genvar p = 0; p < N_PADS; p++) begin : g_pad
    bsr_pad_mux u_mux (
      .extest_i  (extest_i),
      .core_do_i (core_do_i[p]),
      .core_oe_i (core_oe_i[p]),
      .upd_do_i  (upd_q[do_idx(p)]),
      .upd_oe_i  (upd_q[en_idx(p)]),
      .pad_di_i  (pad_di_i[p]),
      .pad_do_o  (pad_do_o[p]),
      .pad_oe_o  (pad_oe_o[p]),
      .cap_en_o  (cap_d[en_idx(p)]),
      .cap_do_o  (cap_d[do_idx(p)])
    );
  end
endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk #(
  parameter int N_PADS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                capture_i,
  input logic                shift_i,
  input logic                update_i,
  input logic                extest_i,
  input logic [N_PADS-1:0]   core_do_i,
  input logic [N_PADS-1:0]   core_oe_i,
  input logic [N_PADS-1:0]   pad_do_o,
  input logic [N_PADS-1:0]   pad_oe_o,
  input logic                tdo_o,
  input logic [2*N_PADS-1:0] scan_q
);
  logic [N_PADS-1:0] sc_en, sc_do;
  for (genvar p = 0; p < N_PADS; p++) begin : g_split
    assign sc_en[p] = scan_q[2*p];
    assign sc_do[p] = scan_q[2*p+1];
  end

  AST_CORE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !extest_i |-> (pad_do_o == core_do_i && pad_oe_o == core_oe_i)); // R7

  AST_PAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!update_i && extest_i) |=> (!extest_i || ($stable(pad_oe_o) && $stable(pad_do_o)))); // R5

  AST_UPD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> (!extest_i || (pad_oe_o == $past(sc_en) && pad_do_o == $past(sc_do)))); // R4

  AST_CAP_EN0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> tdo_o == $past(pad_oe_o[0])); // R2

  AST_SHIFT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !capture_i) |=> tdo_o == $past(scan_q[1])); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !capture_i) |=> $stable(scan_q)); // R9
endmodule

bind bsr_chain bsr_chain_chk #(.N_PADS(N_PADS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .capture_i (capture_i),
  .shift_i   (shift_i),
  .update_i  (update_i),
  .extest_i  (extest_i),
  .core_do_i (core_do_i),
  .core_oe_i (core_oe_i),
  .pad_do_o  (pad_do_o),
  .pad_oe_o  (pad_oe_o),
  .tdo_o     (tdo_o),
  .scan_q    (scan_q)
);

// File: tb/bsr_chain_tb.sv
module bsr_chain_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int L = 2 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic capture = 0, shift = 0, update = 0, extest = 0, tdi = 0;
  logic [N-1:0] core_do = '0, core_oe = '0, pad_di = '0;
  logic [N-1:0] pad_do, pad_oe;
  logic tdo;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsr_chain #(.N_PADS(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .capture_i(capture), .shift_i(shift),
    .update_i(update), .extest_i(extest), .tdi_i(tdi),
    .core_do_i(core_do), .core_oe_i(core_oe), .pad_di_i(pad_di),
    .pad_do_o(pad_do), .pad_oe_o(pad_oe), .tdo_o(tdo)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // expected captured word from pad state
  function automatic logic [L-1:0] cap_word(input logic [N-1:0] oe, input logic [N-1:0] dout,
                                            input logic [N-1:0] di);
    logic [L-1:0] w;
    for (int p = 0; p < N; p++) begin
      w[2*p]   = oe[p];
      w[2*p+1] = oe[p] ? dout[p] : di[p];
    end
    return w;
  endfunction

  function automatic logic [N-1:0] en_of(input logic [L-1:0] w);
    logic [N-1:0] r;
    for (int p = 0; p < N; p++) r[p] = w[2*p];
    return r;
  endfunction

  function automatic logic [N-1:0] do_of(input logic [L-1:0] w);
    logic [N-1:0] r;
    for (int p = 0; p < N; p++) r[p] = w[2*p+1];
    return r;
  endfunction

  task automatic pulse_capture();
    @(negedge clk); capture = 1;
    @(negedge clk); capture = 0;
  endtask

  task automatic pulse_update();
    @(negedge clk); update = 1;
    @(negedge clk); update = 0;
  endtask

  // bit k of vin ends in chain bit k; vout[k] is the old chain bit k
  task automatic shift_vec(input logic [L-1:0] vin, output logic [L-1:0] vout,
                           input bit hold_chk, input logic [N-1:0] h_oe, input logic [N-1:0] h_do);
    for (int i = 0; i < L; i++) begin
      @(negedge clk);
      vout[i] = tdo;
      if (hold_chk) begin
        chk("R5 oe hold during shift", pad_oe, h_oe);
        chk("R5 do hold during shift", pad_do, h_do);
      end
      tdi = vin[i];
      shift = 1;
    end
    @(negedge clk);
    shift = 0;
  endtask

  task automatic t_reset();
    extest = 1;
    @(negedge clk);
    chk("R1 pad_oe after reset", pad_oe, '0);
    chk("R1 pad_do after reset", pad_do, '0);
    chk("R1 tdo after reset", tdo, 0);
  endtask

  task automatic t_sample();
    logic [L-1:0] got, nxt;
    extest = 0;
    core_do = 4'b1010; core_oe = 4'b0110; pad_di = 4'b0011;
    @(negedge clk);
    chk("R7 core data passes", pad_do, 4'b1010);
    chk("R7 core enable passes", pad_oe, 4'b0110);
    pulse_capture();
    chk("R3 tdo is pad0 enable cell", tdo, 0);
    nxt = 8'b0110_1001;
    shift_vec(nxt, got, 0, '0, '0);
    chk("R2 sample capture word", got, cap_word(4'b0110, 4'b1010, 4'b0011));
    pulse_update();
    chk("R7 pads unchanged by update", pad_do, 4'b1010);
    chk("R7 enables unchanged by update", pad_oe, 4'b0110);
    extest = 1;
    @(negedge clk);
    chk("R6 latched enables drive pads", pad_oe, en_of(nxt));
    chk("R6 latched data drive pads", pad_do, do_of(nxt));
    // shift once more to see tdi order emerge
    shift_vec(8'b0, got, 0, '0, '0);
    chk("R3 bits leave in shift-in order", got, nxt);
  endtask

  task automatic t_hold();
    logic [L-1:0] got, nxt;
    logic [N-1:0] o_oe, o_do;
    extest = 1;
    @(negedge clk);
    o_oe = pad_oe; o_do = pad_do;
    nxt = 8'b1111_0101;
    shift_vec(nxt, got, 1, o_oe, o_do);
    pulse_capture();
    chk("R5 oe hold across capture", pad_oe, o_oe);
    chk("R5 do hold across capture", pad_do, o_do);
    shift_vec(nxt, got, 1, o_oe, o_do);
    pulse_update();
    chk("R4 all enables updated together", pad_oe, en_of(nxt));
    chk("R4 all data updated together", pad_do, do_of(nxt));
  endtask

  task automatic t_extest_capture();
    logic [L-1:0] got, pat;
    logic [N-1:0] l_oe, l_do;
    extest = 1;
    l_oe = 4'b1001; l_do = 4'b1100;
    for (int p = 0; p < N; p++) begin
      pat[2*p] = l_oe[p]; pat[2*p+1] = l_do[p];
    end
    shift_vec(pat, got, 0, '0, '0);
    pulse_update();
    pad_di = ~l_do;
    core_do = l_do; core_oe = ~l_oe;
    @(negedge clk);
    chk("R6 mixed enables", pad_oe, l_oe);
    pulse_capture();
    shift_vec('0, got, 0, '0, '0);
    chk("R8 per-pad capture source", got, cap_word(l_oe, l_do, ~l_do));
  endtask

  task automatic t_idle_prio();
    logic [L-1:0] got;
    logic t0;
    extest = 0;
    core_oe = 4'b0001; core_do = 4'b0000; pad_di = 4'b1111;
    pulse_capture();
    t0 = tdo;
    chk("R9 captured enable at tdo", t0, 1);
    repeat (3) @(negedge clk);
    chk("R9 idle hold", tdo, t0);
    core_oe = 4'b1010; core_do = 4'b1000; pad_di = 4'b0101;
    tdi = 1;
    @(negedge clk); capture = 1; shift = 1;
    @(negedge clk); capture = 0; shift = 0;
    shift_vec('0, got, 0, '0, '0);
    chk("R9 capture wins over shift", got, cap_word(4'b1010, 4'b1000, 4'b0101));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sample();
    t_hold();
    t_extest_capture();
    t_idle_prio();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule